// File: doc/BRIEF.md
# Standby and Output-Valid Sequencer

This block steps the converter's digital core between normal operation and a low-power standby. It watches a debounced, active-low standby request and, from a single system clock running at 256 times the sample rate, produces the enables for the logic clock, the analog section and the serial-interface drivers. It also produces two force-low controls: one for the overload flag and one for the serial data line.

Entering standby is a timed power-down. The interface is released at once, and the clock and analog section stay up until the interval ends. Leaving standby is a timed power-up with the interface still released. Then comes a blanking interval. During blanking the interface is driven, but serial data is held low until the decimation chain has produced settled samples. The blanking length is a count of sample periods, and it is much longer when the high-pass filter is enabled. Any request pattern, including a one-cycle pulse, ends in a full and correct recovery.

Top module: `standby_seq`

## Requirements
- R1: While rst_n is low the block is in standby: clk_en=0, ana_en=0, if_oe=0, ovld_low=1, sdo_low=1.
- R2: In standby the outputs stay {clk_en,ana_en,if_oe,ovld_low,sdo_low}=00011 for as long as stby_n is low.
- R3: In normal operation, stby_n low starts power-down on the next clock. For DOWN_CYCLES clocks the outputs are 11011 (interface released and overload forced low, clock and analog kept). After that the block is in standby (00011).
- R4: In standby, stby_n high starts recovery on the next clock. For UP_CYCLES clocks the outputs are 11011.
- R5: After recovery comes blanking, with outputs 11101 (interface driven, serial data forced low). When hp_en was low at the start of blanking, blanking lasts BLANK_PLAIN*TICK_DIV clocks.
- R6: When hp_en was high at the start of blanking, blanking lasts BLANK_HPF*TICK_DIV clocks.
- R7: hp_en is sampled only when blanking starts. A change during blanking has no effect on its length.
- R8: stby_n low during recovery or blanking aborts it and starts a full power-down. The next recovery reloads the full blanking count.
- R9: stby_n high during power-down is ignored until power-down completes. The block then spends one clock in standby and starts recovery.
- R10: A stby_n low pulse of a single clock still runs a full power-down, standby, recovery and blanking, and ends in normal operation.
- R11: In normal operation the outputs are 11100: everything enabled and nothing forced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n | input | 1 | Debounced standby request, low requests standby |
| hp_en | input | 1 | High-pass filter enabled, selects the long blanking |
| clk_en | output | 1 | Logic-clock enable |
| ana_en | output | 1 | Analog section enable |
| if_oe | output | 1 | Serial interface output enable |
| ovld_low | output | 1 | Forces the overload output low |
| sdo_low | output | 1 | Forces serial data low |

## Verification
A wrong state or a miscounted interval shows at the ports as an output pattern that changes one clock early or late. Each interval is therefore checked on the last clock of the old pattern and on the first clock of the new one. Power-down and recovery share the pattern 11011, so a missed abort stays hidden until the clock enable should drop. The checks look for that drop exactly DOWN_CYCLES+1 clocks after the abort. A stale blanking count shows only at the end of the following blanking interval, which is why every recovery after an abort is timed in full.

// File: rtl/standby_seq.sv
module standby_seq #(
  parameter int DOWN_CYCLES = 32,
  parameter int UP_CYCLES   = 256,
  parameter int TICK_DIV    = 256,
  parameter int BLANK_PLAIN = 1024,
  parameter int BLANK_HPF   = 12288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_n,
  input  logic hp_en,
  output logic clk_en,
  output logic ana_en,
  output logic if_oe,
  output logic ovld_low,
  output logic sdo_low
);

  localparam int CMAX = (DOWN_CYCLES > UP_CYCLES) ?
                        ((DOWN_CYCLES > TICK_DIV) ? DOWN_CYCLES : TICK_DIV) :
                        ((UP_CYCLES > TICK_DIV) ? UP_CYCLES : TICK_DIV);
  localparam int CW   = $clog2(CMAX + 1);
  localparam int BMAX = (BLANK_HPF > BLANK_PLAIN) ? BLANK_HPF : BLANK_PLAIN;
  localparam int BW   = $clog2(BMAX + 1);

  typedef enum logic [2:0] {S_RUN, S_DOWN, S_OFF, S_WAKE, S_BLANK} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      cnt   <= '0;
      blk   <= '0;
    end else begin
      case (state)
        S_RUN:
          if (!stby_n) begin
            state <= S_DOWN;
            cnt   <= CW'(DOWN_CYCLES - 1);
          end
        S_DOWN:
          if (cnt == '0) state <= S_OFF;
          else           cnt   <= cnt - 1'b1;
        S_OFF:
          if (stby_n) begin
            state <= S_WAKE;
            cnt   <= CW'(UP_CYCLES - 1);
          end
        S_WAKE:
          if (!stby_n) begin
            state <= S_DOWN;
            cnt   <= CW'(DOWN_CYCLES - 1);
          end else if (cnt == '0) begin
            state <= S_BLANK;
            cnt   <= CW'(TICK_DIV - 1);
            blk   <= hp_en ? BW'(BLANK_HPF - 1) : BW'(BLANK_PLAIN - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_BLANK:
          if (!stby_n) begin
            state <= S_DOWN;
            cnt   <= CW'(DOWN_CYCLES - 1);
          end else if (cnt == '0) begin
            cnt <= CW'(TICK_DIV - 1);
            if (blk == '0) state <= S_RUN;
            else           blk   <= blk - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        default: state <= S_OFF;
      endcase
    end
  end

  wire live = (state == S_RUN) || (state == S_BLANK);

  assign clk_en   = (state != S_OFF);
  assign ana_en   = (state != S_OFF);
  assign if_oe    = live;
  assign ovld_low = !live;
  assign sdo_low  = (state != S_RUN);

  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> (!ana_en && !if_oe && ovld_low && sdo_low));

  p_oe_needs_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
    if_oe |-> (clk_en && ana_en && !ovld_low));

  p_clean_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_low |-> (if_oe && clk_en));

  p_release_keeps_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(if_oe) |-> clk_en);

  p_clk_off_after_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> ($past(state) == S_DOWN && $past(cnt) == '0));

  p_wake_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> !if_oe);

  p_blank_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_oe) |-> sdo_low);

  p_blk_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BLANK) |-> (int'(blk) < BMAX));

endmodule

// File: tb/standby_seq_tb.sv
module standby_seq_tb;
  localparam int DN = 8, UP = 16, TK = 4, BP = 5, BH = 12;
  localparam logic [4:0] P_OFF = 5'b00011, P_MID = 5'b11011,
                         P_BLK = 5'b11101, P_RUN = 5'b11100;

  logic clk = 1'b0, rst_n = 1'b0, stby_n = 1'b0, hp_en = 1'b0;
  logic clk_en, ana_en, if_oe, ovld_low, sdo_low;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  standby_seq #(.DOWN_CYCLES(DN), .UP_CYCLES(UP), .TICK_DIV(TK),
                .BLANK_PLAIN(BP), .BLANK_HPF(BH)) u_dut (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .hp_en(hp_en),
    .clk_en(clk_en), .ana_en(ana_en), .if_oe(if_oe),
    .ovld_low(ovld_low), .sdo_low(sdo_low));

  wire [4:0] outs = {clk_en, ana_en, if_oe, ovld_low, sdo_low};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [4:0] exp, input string tag);
    tests++;
    if (outs !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag, outs, exp, $time);
    end
  endtask

  task automatic do_wake(input logic hp, input int nb, input logic flip, input string tag);
    stby_n = 1'b1; hp_en = hp;
    step(1);       chk(P_MID, {tag, " R4 recovery start"});
    step(UP - 1);  chk(P_MID, {tag, " R4 recovery last"});
    step(1);       chk(P_BLK, {tag, " R5 blanking start"});
    if (flip) hp_en = !hp;
    step(nb * TK - 1); chk(P_BLK, {tag, " blanking last"});
    step(1);       chk(P_RUN, {tag, " R11 run"});
  endtask

  task automatic do_down(input string tag);
    stby_n = 1'b0;
    step(1);       chk(P_MID, {tag, " R3 power-down start"});
    step(DN - 1);  chk(P_MID, {tag, " R3 power-down last"});
    step(1);       chk(P_OFF, {tag, " R3 standby reached"});
  endtask

  task automatic t_reset;
    step(2); chk(P_OFF, "R1 in reset");
    rst_n = 1'b1;
    step(30); chk(P_OFF, "R2 standby held");
  endtask

  task automatic t_wake_plain; do_wake(1'b0, BP, 1'b0, "R5 plain"); endtask
  task automatic t_wake_hpf;   do_wake(1'b1, BH, 1'b0, "R6 hpf");  endtask
  task automatic t_hp_flip;    do_wake(1'b0, BP, 1'b1, "R7 flip"); endtask

  task automatic t_abort_wake;
    stby_n = 1'b1; step(3); chk(P_MID, "R8 in recovery");
    stby_n = 1'b0;
    step(DN); chk(P_MID, "R8 abort power-down last");
    step(1);  chk(P_OFF, "R8 abort from recovery reaches standby");
  endtask

  task automatic t_abort_blank;
    stby_n = 1'b1; step(UP + 1 + 2 * TK + 1); chk(P_BLK, "R8 in blanking");
    stby_n = 1'b0;
    step(1);  chk(P_MID, "R8 blanking aborted");
    step(DN); chk(P_OFF, "R8 abort from blanking reaches standby");
    do_wake(1'b0, BP, 1'b0, "R8 reload");
  endtask

  task automatic t_wake_in_down;
    stby_n = 1'b0; step(2);
    stby_n = 1'b1;
    step(DN - 2); chk(P_MID, "R9 power-down not cut short");
    step(1);      chk(P_OFF, "R9 one standby clock");
    step(1);      chk(P_MID, "R9 recovery follows");
    step(UP + BP * TK); chk(P_RUN, "R9 back to run");
  endtask

  task automatic t_short_pulse;
    stby_n = 1'b0; step(1); stby_n = 1'b1;
    step(DN); chk(P_OFF, "R10 short pulse still powers down");
    step(1);  chk(P_MID, "R10 recovery");
    step(UP + BP * TK - 1); chk(P_BLK, "R10 blanking last");
    step(1);  chk(P_RUN, "R10 run restored");
  endtask

  initial begin
    #(100000 * 5);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(1);
    t_reset;
    t_wake_plain;
    do_down("R3 a");
    t_wake_hpf;
    do_down("R3 b");
    t_hp_flip;
    do_down("R3 c");
    t_abort_wake;
    t_abort_blank;
    t_wake_in_down;
    t_short_pulse;
    step(20); chk(P_RUN, "R11 run stays");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule